// File: doc/BRIEF.md
# Occupancy-Gated Destage Enable with Least-Cost Track Batching

This block decides when a disk's background flush of dirty write-cache blocks may run, and which pending flush to start next. It compares the current write-cache fill count against two marks derived from the cache size. The flush process switches on once the fill count climbs past the upper mark and switches off once it sinks under the lower mark. In the band between the marks it keeps whatever state it had, so short bursts do not make it toggle.

While the flush process is on, the block looks at each edge of the clock for a disk that is idle and has no host reads waiting. If it finds one, it picks the valid candidate with the smallest service-time cost from a fixed table of pending flush entries. One cycle later it issues that entry together with every other valid entry on the same track, as a bit mask over the table. The cost values are computed elsewhere. Sequencing the disk operations is also done elsewhere.

Top module: `destage_hyst_ctrl`

## Requirements
- R1: The upper mark is floor(capacity*7/10). On a clock edge where occupancy is strictly greater than the upper mark, `dstg_en` is 1 after that edge.
- R2: The lower mark is floor(capacity*3/10). On a clock edge where occupancy is strictly less than the lower mark and not above the upper mark, `dstg_en` is 0 after that edge.
- R3: When occupancy lies between the two marks, ends included, `dstg_en` keeps its value across the edge.
- R4: While `rst_n` is low, `dstg_en`, `issue_vld` and `issue_mask` are all 0.
- R5: On an edge where `dstg_en`, `disk_idle` and `rdq_empty` are all 1 and at least one `cand_valid` bit is set, `issue_vld` is 1 after that edge. The `dstg_en` value used is the one held before the edge.
- R6: On an edge where any of `dstg_en`, `disk_idle` or `rdq_empty` is 0, `issue_vld` is 0 after that edge and `issue_mask` is all zero.
- R7: The chosen entry is the valid entry with the lowest cost. Entry i's cost is `cand_cost[i*COST_W +: COST_W]`. On equal costs, the lowest index wins. `issue_track` carries the chosen entry's track, `cand_track[i*TRK_W +: TRK_W]`.
- R8: When an issue occurs, bit i of `issue_mask` is 1 exactly when entry i is valid and its track equals the chosen entry's track. The chosen entry's bit is always 1.
- R9: When `dstg_en` is 1 but no `cand_valid` bit is set, no issue occurs and `issue_mask` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occupancy | input | OCC_W | Current count of dirty blocks in the write cache |
| capacity | input | OCC_W | Write-cache size in blocks |
| disk_idle | input | 1 | Disk has finished its last operation and can take a new one |
| rdq_empty | input | 1 | No host reads are queued for this disk |
| cand_valid | input | N_ENT | Pending-flush table valid bits |
| cand_cost | input | N_ENT*COST_W | Packed service-time cost per entry |
| cand_track | input | N_ENT*TRK_W | Packed track number per entry |
| dstg_en | output | 1 | Flush process enabled |
| issue_vld | output | 1 | A batch is being issued this cycle |
| issue_mask | output | N_ENT | Entries in the issued batch |
| issue_track | output | TRK_W | Track of the issued batch |

## Verification
The bench drives occupancy exactly onto each mark and one step past it, starting from both enable states. A design using non-strict comparisons would flip the enable when occupancy sits on a mark. A design using wrong rounding would flip it one count early. Random costs are drawn from a narrow range so that ties are frequent. A winner chosen by highest index, or by the first valid entry without regard to cost, then shows up as a wrong `issue_track` or mask. The bench also checks an enabled controller with an empty table, and idle cycles with host reads pending. A design that ignores either gate would issue a batch when it should not.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

   // floor(cap * num / den) in unsigned 32-bit arithmetic
   function automatic int unsigned scaled_mark(input int unsigned cap,
                                               input int unsigned num,
                                               input int unsigned den);
      return (cap * num) / den;
   endfunction

endpackage

// File: rtl/dhc_marks.sv
module dhc_marks #(
   parameter int OCC_W  = 12,
   parameter int HI_NUM = 7,
   parameter int LO_NUM = 3,
   parameter int DEN    = 10
) (
   input  logic [OCC_W-1:0] capacity,
   output logic [OCC_W-1:0] hi_mark,
   output logic [OCC_W-1:0] lo_mark
);
   import dhc_pkg::*;

   if (OCC_W > 28) begin : g_bad_w
      $error("dhc_marks: OCC_W too wide for 32-bit mark arithmetic");
   end
   if (LO_NUM > HI_NUM || HI_NUM > DEN) begin : g_bad_ratio
      $error("dhc_marks: mark ratios must satisfy LO_NUM <= HI_NUM <= DEN");
   end

   int unsigned hi_full, lo_full;

   always_comb begin
      hi_full = scaled_mark(int'(capacity), HI_NUM, DEN);
      lo_full = scaled_mark(int'(capacity), LO_NUM, DEN);
      hi_mark = hi_full[OCC_W-1:0];
      lo_mark = lo_full[OCC_W-1:0];
   end
endmodule

// File: rtl/dhc_hyst.sv
module dhc_hyst #(
   parameter int OCC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occupancy,
   input  logic [OCC_W-1:0] hi_mark,
   input  logic [OCC_W-1:0] lo_mark,
   output logic             en
);
   logic en_nxt;

   always_comb begin
      en_nxt = en;
      if (occupancy > hi_mark)      en_nxt = 1'b1;
      else if (occupancy < lo_mark) en_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) en <= 1'b0;
      else        en <= en_nxt;
   end

   assert_rise_above_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy > hi_mark) |=> en);

   assert_fall_below_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy < lo_mark && occupancy <= hi_mark) |=> !en);

   assert_hold_in_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy >= lo_mark && occupancy <= hi_mark) |=> (en == $past(en)));
endmodule

// File: rtl/dhc_argmin.sv
module dhc_argmin #(
   parameter int N_ENT  = 8,
   parameter int COST_W = 8,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_ENT-1:0]        valid,
   input  logic [N_ENT*COST_W-1:0] cost,
   output logic                    found,
   output logic [IDX_W-1:0]        win_idx,
   output logic [COST_W-1:0]       win_cost
);
   logic [N_ENT:0]             chain_found;
   logic [N_ENT:0][IDX_W-1:0]  chain_idx;
   logic [N_ENT:0][COST_W-1:0] chain_cost;

   assign chain_found[0] = 1'b0;
   assign chain_idx[0]   = '0;
   assign chain_cost[0]  = '0;

   for (genvar i = 0; i < N_ENT; i++) begin : g_stage
      logic [COST_W-1:0] c_i;
      logic              take;
      assign c_i  = cost[i*COST_W +: COST_W];
      // strict compare keeps the lower index on ties
      assign take = valid[i] && (!chain_found[i] || (c_i < chain_cost[i]));
      assign chain_found[i+1] = chain_found[i] | valid[i];
      assign chain_idx[i+1]   = take ? IDX_W'(i) : chain_idx[i];
      assign chain_cost[i+1]  = take ? c_i       : chain_cost[i];

      assert_min_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
         valid[i] |-> (c_i >= chain_cost[N_ENT]));
   end

   assign found    = chain_found[N_ENT];
   assign win_idx  = chain_idx[N_ENT];
   assign win_cost = chain_cost[N_ENT];
endmodule

// File: rtl/destage_hyst_ctrl.sv
module destage_hyst_ctrl #(
   parameter int OCC_W  = 12,
   parameter int N_ENT  = 8,
   parameter int COST_W = 8,
   parameter int TRK_W  = 6,
   parameter int HI_NUM = 7,
   parameter int LO_NUM = 3,
   parameter int DEN    = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [OCC_W-1:0]        occupancy,
   input  logic [OCC_W-1:0]        capacity,
   input  logic                    disk_idle,
   input  logic                    rdq_empty,
   input  logic [N_ENT-1:0]        cand_valid,
   input  logic [N_ENT*COST_W-1:0] cand_cost,
   input  logic [N_ENT*TRK_W-1:0]  cand_track,
   output logic                    dstg_en,
   output logic                    issue_vld,
   output logic [N_ENT-1:0]        issue_mask,
   output logic [TRK_W-1:0]        issue_track
);
   localparam int IDX_W = $clog2(N_ENT);

   if (N_ENT < 2) begin : g_bad_n
      $error("destage_hyst_ctrl: N_ENT must be at least 2");
   end

   logic [OCC_W-1:0]  hi_mark, lo_mark;
   logic              found;
   logic [IDX_W-1:0]  win_idx;
   logic [COST_W-1:0] win_cost;
   logic [TRK_W-1:0]  win_track;
   logic [N_ENT-1:0]  batch;
   logic              go;

   dhc_marks #(.OCC_W(OCC_W), .HI_NUM(HI_NUM), .LO_NUM(LO_NUM), .DEN(DEN)) u_marks (
      .capacity(capacity), .hi_mark(hi_mark), .lo_mark(lo_mark));

   dhc_hyst #(.OCC_W(OCC_W)) u_hyst (
      .clk(clk), .rst_n(rst_n), .occupancy(occupancy),
      .hi_mark(hi_mark), .lo_mark(lo_mark), .en(dstg_en));

   dhc_argmin #(.N_ENT(N_ENT), .COST_W(COST_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .valid(cand_valid), .cost(cand_cost),
      .found(found), .win_idx(win_idx), .win_cost(win_cost));

   assign win_track = cand_track[win_idx*TRK_W +: TRK_W];

   for (genvar j = 0; j < N_ENT; j++) begin : g_batch
      assign batch[j] = cand_valid[j] && (cand_track[j*TRK_W +: TRK_W] == win_track);
   end

   assign go = dstg_en && disk_idle && rdq_empty && found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_vld   <= 1'b0;
         issue_mask  <= '0;
         issue_track <= '0;
      end else begin
         issue_vld   <= go;
         issue_mask  <= go ? batch : '0;
         issue_track <= go ? win_track : issue_track;
      end
   end

   assert_gate_on_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vld |-> $past(dstg_en && disk_idle && rdq_empty));

   assert_batch_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vld |-> (issue_mask != '0));

   assert_idle_mask_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_vld |-> (issue_mask == '0));

   assert_empty_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid == '0) |=> !issue_vld);

   assert_issue_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dstg_en && disk_idle && rdq_empty && (cand_valid != '0)) |=> issue_vld);
endmodule

// File: tb/sim_destage_hyst_ctrl.sv
module sim_destage_hyst_ctrl;
   localparam int OCC_W = 12, N = 8, CW = 8, TW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [OCC_W-1:0] occ = '0, cap = '0;
   logic idle = 1'b0, rdq = 1'b0;
   logic [N-1:0] vld = '0;
   logic [CW-1:0] cost [N];
   logic [TW-1:0] trk [N];
   logic [N*CW-1:0] cost_bus;
   logic [N*TW-1:0] trk_bus;
   logic dstg_en, issue_vld;
   logic [N-1:0] issue_mask;
   logic [TW-1:0] issue_track;

   int total = 0, bad = 0;
   bit model_en = 0;
   bit done = 0;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         cost_bus[i*CW +: CW] = cost[i];
         trk_bus[i*TW +: TW]  = trk[i];
      end
   end

   destage_hyst_ctrl #(.OCC_W(OCC_W), .N_ENT(N), .COST_W(CW), .TRK_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .occupancy(occ), .capacity(cap),
      .disk_idle(idle), .rdq_empty(rdq), .cand_valid(vld),
      .cand_cost(cost_bus), .cand_track(trk_bus), .dstg_en(dstg_en),
      .issue_vld(issue_vld), .issue_mask(issue_mask), .issue_track(issue_track));

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(string ctx);
      int hi, lo, best, bestc;
      bit e_en, e_go;
      int e_mask, e_trk;
      string en_tag, go_tag;
      hi = (int'(cap) * 7) / 10;
      lo = (int'(cap) * 3) / 10;
      e_en = model_en;
      en_tag = "R3";
      if (int'(occ) > hi)      begin e_en = 1; en_tag = "R1"; end
      else if (int'(occ) < lo) begin e_en = 0; en_tag = "R2"; end
      best = -1; bestc = 0;
      for (int i = 0; i < N; i++)
         if (vld[i] && (best < 0 || int'(cost[i]) < bestc)) begin best = i; bestc = int'(cost[i]); end
      e_go = model_en && idle && rdq && (best >= 0);
      go_tag = (best < 0) ? "R9" : (e_go ? "R5" : "R6");
      e_mask = 0; e_trk = 0;
      if (e_go) begin
         e_trk = int'(trk[best]);
         for (int i = 0; i < N; i++)
            if (vld[i] && trk[i] == trk[best]) e_mask |= (1 << i);
      end
      @(negedge clk);
      chk({en_tag, " dstg_en ", ctx}, int'(dstg_en), int'(e_en));
      chk({go_tag, " issue_vld ", ctx}, int'(issue_vld), int'(e_go));
      chk({"R8 issue_mask ", ctx}, int'(issue_mask), e_mask);
      if (e_go) chk({"R7 issue_track ", ctx}, int'(issue_track), e_trk);
      model_en = e_en;
   endtask

   task automatic set_table(bit [N-1:0] v);
      vld = v;
      for (int i = 0; i < N; i++) begin
         cost[i] = CW'(i + 10);
         trk[i]  = TW'(i);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin cost[i] = '0; trk[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R4 dstg_en reset", int'(dstg_en), 0);
      chk("R4 issue_vld reset", int'(issue_vld), 0);
      chk("R4 issue_mask reset", int'(issue_mask), 0);
      rst_n = 1'b1;

      // directed: capacity 100 -> hi 70, lo 30
      cap = 100; idle = 1; rdq = 1; set_table('0);
      occ = 70; step("on hi mark, off");
      occ = 50; step("band, off");
      occ = 71; step("above hi");
      occ = 70; step("on hi mark, on");
      occ = 30; step("on lo mark, on");
      set_table('0); step("empty table enabled");
      set_table(8'b0010_0100);
      cost[2] = 5; cost[5] = 5; trk[5] = 9; step("tie lowest index");
      set_table(8'b1111_1111);
      cost[6] = 1; trk[6] = 3; trk[1] = 3; trk[7] = 3; step("batch same track");
      rdq = 0; step("reads queued");
      rdq = 1; idle = 0; step("disk busy");
      idle = 1; occ = 29; step("below lo");
      occ = 50; step("band after off, table full");
      cap = 5; occ = 3; step("small cap on hi"); // hi 3, lo 1
      occ = 4; step("small cap above hi");
      occ = 1; step("small cap on lo");
      occ = 0; step("small cap below lo");

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         cap  = OCC_W'($urandom_range(1, 2000));
         occ  = OCC_W'($urandom_range(0, int'(cap)));
         idle = ($urandom_range(0, 3) != 0);
         rdq  = ($urandom_range(0, 3) != 0);
         vld  = ($urandom_range(0, 7) == 0) ? '0 : N'($urandom);
         for (int i = 0; i < N; i++) begin
            cost[i] = CW'($urandom_range(0, 5));
            trk[i]  = TW'($urandom_range(0, 3));
         end
         step("random");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule